// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block is the register front end for one 8-pin general-purpose I/O port. A processor reaches it over a plain memory-mapped bus: an address, a 32-bit write word with a write strobe, and a 32-bit read word qualified by a read strobe. Through it software chooses each pin's function, its direction and output level, and its pull-up. Software also reads the pin levels. Every setting goes out on dedicated outputs to the pad ring and to an external pin multiplexer.

The output latch has two extra write paths. A set register drives to 1 every output bit written as 1, and a clear register drives to 0 every output bit written as 1. With these, one pin can be changed without a read-modify-write sequence. Input levels pass through a two-flop synchronizer before software can read them. On the first clock edge after reset is released, the block records the pin levels in a snapshot that can only be read. A build parameter removes pull-up control for ports whose pads have no pull-ups.

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is asserted and after it, padOutEn and padOut are 0, padFuncSel is 0, and padPullEn is all ones (HAS_PULLUP=1).
- R2: A write to offset 4*PORT_INDEX (0x00 by default) loads the function select. Pin i uses write bits [2i+1:2i], which appear on padFuncSel[2i+1:2i] after the next clock edge and read back at that offset in the same positions. Writes to the other word slots below 0x20 change nothing.
- R3: A write to the data word at 0x20 loads direction from bits [31:24] (1 = output) onto padOutEn and output values from bits [23:16] onto padOut, after the next clock edge. Bits [15:0] of that write have no effect.
- R4: A read of 0x20 returns direction in [31:24], the output latch in [23:16], the reset snapshot in [15:8] and the synchronized pin levels in [7:0]. A pin change appears in [7:0] after the second rising clock edge that follows it, and not after the first.
- R5: The snapshot holds padIn as sampled on the first clock edge after reset is released. It never changes afterwards, whether pins change or software writes.
- R6: A write to 0x24 sets padOut[i] to 1 for every write bit i in [7:0] that is 1, and leaves the other bits unchanged. The offset reads as 0.
- R7: A write to 0x28 clears padOut[i] to 0 for every write bit i in [7:0] that is 1, and leaves the other bits unchanged. The offset reads as 0.
- R8: A write to 0x2C loads bits [7:0] onto padPullEn (1 = pull-up on), and the offset reads them back. With HAS_PULLUP=0, padPullEn is 0 and the offset reads 0.
- R9: busRdData is 0 whenever busRd is low or the address matches no register, and a read changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte offset of the register |
| busWrData | input | 32 | Write word |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe, qualifies busRdData |
| busRdData | output | 32 | Read word, combinational from the address |
| padIn | input | 8 | Pin levels from the pads |
| padOutEn | output | 8 | Per-pin output enable |
| padOut | output | 8 | Per-pin output value |
| padPullEn | output | 8 | Per-pin pull-up enable |
| padFuncSel | output | 16 | Two function-select bits per pin for the pin multiplexer |

## Verification
A corrupted output latch appears on padOut on the edge after the faulty write. It also shows in data-word bits [23:16] at the next read, so a random sequence of set, clear and full writes exposes it after the first operation that touches the bit. A synchronizer that is one flop short or one flop long shows up as a pin level that is visible one edge early or one edge late. A snapshot that is recaptured or taken on the wrong edge shows up in bits [15:8] once the pins move away from their reset-time pattern.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CFG  = 2'd1,
    RD_DATA = 2'd2,
    RD_PULL = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrCfg;
    logic   wrData;
    logic   wrSet;
    logic   wrClr;
    logic   wrPull;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PORT_INDEX = 0
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output regStrobe_t        strb
);

  localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'(4 * PORT_INDEX);
  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] OFS_SET  = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] OFS_CLR  = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] OFS_PULL = ADDR_W'(8'h2C);

  logic hitCfg, hitData, hitSet, hitClr, hitPull;

  always_comb begin
    hitCfg  = (busAddr == OFS_CFG);
    hitData = (busAddr == OFS_DATA);
    hitSet  = (busAddr == OFS_SET);
    hitClr  = (busAddr == OFS_CLR);
    hitPull = (busAddr == OFS_PULL);
  end

  always_comb begin
    strb.wrCfg  = busWr & hitCfg;
    strb.wrData = busWr & hitData;
    strb.wrSet  = busWr & hitSet;
    strb.wrClr  = busWr & hitClr;
    strb.wrPull = busWr & hitPull;
    strb.rdSel  = RD_NONE;
    if (busRd) begin
      if (hitCfg)       strb.rdSel = RD_CFG;
      else if (hitData) strb.rdSel = RD_DATA;
      else if (hitPull) strb.rdSel = RD_PULL;
    end
  end

  always_comb begin
    AST_ONE_WRITE: assert ($onehot0({strb.wrCfg, strb.wrData, strb.wrSet, strb.wrClr, strb.wrPull})); // R9
    AST_IDLE_NO_READ: assert (busRd || strb.rdSel == RD_NONE); // R9
  end

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT  = 8,
  parameter int FUNC_W     = 2,
  parameter bit HAS_PULLUP = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  regStrobe_t                    strb,
  input  logic [4*PIN_COUNT-1:0]        busWrData,
  input  logic [PIN_COUNT-1:0]          padIn,
  output logic [4*PIN_COUNT-1:0]        rdWord,
  output logic [PIN_COUNT-1:0]          padOutEn,
  output logic [PIN_COUNT-1:0]          padOut,
  output logic [PIN_COUNT-1:0]          padPullEn,
  output logic [FUNC_W*PIN_COUNT-1:0]   padFuncSel
);

  localparam int WORD_W = 4 * PIN_COUNT;
  localparam int SEL_W  = FUNC_W * PIN_COUNT;
  localparam int DIR_LO = 3 * PIN_COUNT;
  localparam int OUT_LO = 2 * PIN_COUNT;
  localparam int SNP_LO = PIN_COUNT;

  logic [PIN_COUNT-1:0] wrMask;
  logic [PIN_COUNT-1:0] syncA, syncB;
  logic [PIN_COUNT-1:0] snapReg;
  logic                 snapTaken;

  assign wrMask = busWrData[PIN_COUNT-1:0];

  // two-stage input synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  // one-time snapshot of pin levels after reset release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snapReg   <= '0;
      snapTaken <= 1'b0;
    end else if (!snapTaken) begin
      snapReg   <= padIn;
      snapTaken <= 1'b1;
    end
  end

  // direction and output latch; a full data write, a set and a clear are exclusive in a cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      padOutEn <= '0;
      padOut   <= '0;
    end else begin
      if (strb.wrData) begin
        padOutEn <= busWrData[DIR_LO +: PIN_COUNT];
        padOut   <= busWrData[OUT_LO +: PIN_COUNT];
      end else if (strb.wrClr) begin
        padOut <= padOut & ~wrMask;
      end else if (strb.wrSet) begin
        padOut <= padOut | wrMask;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) padFuncSel <= '0;
    else if (strb.wrCfg) padFuncSel <= busWrData[SEL_W-1:0];
  end

  generate
    if (HAS_PULLUP) begin : g_pull
      logic [PIN_COUNT-1:0] pullReg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pullReg <= '1;
        else if (strb.wrPull) pullReg <= wrMask;
      end
      assign padPullEn = pullReg;
    end else begin : g_nopull
      assign padPullEn = '0;
    end
  endgenerate

  always_comb begin
    rdWord = '0;
    unique case (strb.rdSel)
      RD_CFG:  rdWord[SEL_W-1:0] = padFuncSel;
      RD_DATA: rdWord = {padOutEn, padOut, snapReg, syncB};
      RD_PULL: rdWord[PIN_COUNT-1:0] = padPullEn;
      default: rdWord = '0;
    endcase
  end

  AST_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrSet |=> ((padOut & $past(wrMask)) == $past(wrMask))); // R6
  AST_SET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrSet |=> ((padOut & ~$past(wrMask)) == ($past(padOut) & ~$past(wrMask)))); // R6
  AST_CLR_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrClr |=> ((padOut & $past(wrMask)) == '0)); // R7
  AST_CLR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrClr |=> ((padOut & ~$past(wrMask)) == ($past(padOut) & ~$past(wrMask)))); // R7
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    snapTaken |=> $stable(snapReg)); // R5
  AST_FUNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wrCfg |=> $stable(padFuncSel)); // R2
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wrData |=> $stable(padOutEn)); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.wrData || strb.wrSet || strb.wrClr) |=> $stable(padOut)); // R9

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT  = 8,
  parameter int FUNC_W     = 2,
  parameter int ADDR_W     = 8,
  parameter int PORT_INDEX = 0,
  parameter bit HAS_PULLUP = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [4*PIN_COUNT-1:0]      busWrData,
  input  logic                        busWr,
  input  logic                        busRd,
  output logic [4*PIN_COUNT-1:0]      busRdData,
  input  logic [PIN_COUNT-1:0]        padIn,
  output logic [PIN_COUNT-1:0]        padOutEn,
  output logic [PIN_COUNT-1:0]        padOut,
  output logic [PIN_COUNT-1:0]        padPullEn,
  output logic [FUNC_W*PIN_COUNT-1:0] padFuncSel
);

  regStrobe_t strb;

  gpio_port_ctrl #(
    .ADDR_W     (ADDR_W),
    .PORT_INDEX (PORT_INDEX)
  ) i_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .strb    (strb)
  );

  gpio_port_dp #(
    .PIN_COUNT  (PIN_COUNT),
    .FUNC_W     (FUNC_W),
    .HAS_PULLUP (HAS_PULLUP)
  ) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .busWrData  (busWrData),
    .padIn      (padIn),
    .rdWord     (busRdData),
    .padOutEn   (padOutEn),
    .padOut     (padOut),
    .padPullEn  (padPullEn),
    .padFuncSel (padFuncSel)
  );

  AST_RESET_OUTS: assert property (@(posedge clk) !rst_n |-> (padOutEn == '0 && padOut == '0)); // R1

endmodule

// File: tb/test_gpio_port_regs.sv
`timescale 1ns/1ps
module test_gpio_port_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busRdData;
  logic [7:0]  padIn = 8'hA5;
  logic [7:0]  padOutEn, padOut, padPullEn;
  logic [15:0] padFuncSel;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic [7:0]  mDir = '0, mOut = '0, mPull = 8'hFF, mSnap = '0, mPin = '0;
  logic [15:0] mFunc = '0;

  always #2.5 clk = ~clk;

  gpio_port_regs i_gpio_port_regs (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .busRdData(busRdData), .padIn(padIn),
    .padOutEn(padOutEn), .padOut(padOut), .padPullEn(padPullEn), .padFuncSel(padFuncSel)
  );

  function automatic logic [31:0] expData();
    return {mDir, mOut, mSnap, mPin};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdData;
    busRd = 1'b0;
  endtask

  task automatic checkOutputs(input string req);
    chk({req, " padOutEn"}, 32'(padOutEn), 32'(mDir));
    chk({req, " padOut"}, 32'(padOut), 32'(mOut));
    chk({req, " padPullEn"}, 32'(padPullEn), 32'(mPull));
    chk({req, " padFuncSel"}, 32'(padFuncSel), 32'(mFunc));
  endtask

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20251));

    // R1 reset state, with reset still asserted
    #7;
    checkOutputs("R1 in reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk) #1 padIn = 8'h3C;   // R5 snapshot already taken at this edge
    mSnap = 8'hA5;
    checkOutputs("R1 after reset");
    repeat (2) @(negedge clk);
    mPin = 8'h3C;
    busRead(8'h20, rd);
    chk("R5 snapshot / R4 layout", rd, expData());

    // R4 synchronizer latency: visible after two edges, not one
    @(negedge clk);
    padIn = 8'hC3; busAddr = 8'h20; busRd = 1'b1;
    @(posedge clk) #1 chk("R4 one edge old", 32'(busRdData[7:0]), 32'h3C);
    @(posedge clk) #1 chk("R4 two edges new", 32'(busRdData[7:0]), 32'hC3);
    busRd = 1'b0; mPin = 8'hC3;

    // R3 data write, low half ignored
    busWrite(8'h20, 32'hF00F_FFFF);
    mDir = 8'hF0; mOut = 8'h0F;
    checkOutputs("R3 data write");
    busRead(8'h20, rd);
    chk("R3/R5 low half ignored", rd, expData());

    // R6 / R7 set and clear
    busWrite(8'h24, 32'h0000_00A0);
    mOut = mOut | 8'hA0;
    chk("R6 set", 32'(padOut), 32'(mOut));
    busWrite(8'h28, 32'h0000_0003);
    mOut = mOut & ~8'h03;
    chk("R7 clear", 32'(padOut), 32'(mOut));
    busRead(8'h24, rd); chk("R6 set reads zero", rd, 32'h0);
    busRead(8'h28, rd); chk("R7 clear reads zero", rd, 32'h0);

    // R2 config and other port slots
    busWrite(8'h00, 32'hFFFF_9C36);
    mFunc = 16'h9C36;
    chk("R2 func out", 32'(padFuncSel), 32'(mFunc));
    busRead(8'h00, rd); chk("R2 func readback", rd, 32'(mFunc));
    busWrite(8'h04, 32'h0000_1111);
    busWrite(8'h1C, 32'h0000_2222);
    chk("R2 other slot ignored", 32'(padFuncSel), 32'(mFunc));

    // R8 pull-ups
    busWrite(8'h2C, 32'hFFFF_FF5A);
    mPull = 8'h5A;
    chk("R8 pull out", 32'(padPullEn), 32'(mPull));
    busRead(8'h2C, rd); chk("R8 pull readback", rd, 32'(mPull));

    // R9 unmapped and idle reads
    busRead(8'h30, rd); chk("R9 unmapped read", rd, 32'h0);
    busRead(8'h04, rd); chk("R9 other slot read", rd, 32'h0);
    @(negedge clk); busAddr = 8'h20; #1 chk("R9 idle read", busRdData, 32'h0);
    checkOutputs("R9 no side effect");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      logic [31:0] v;
      op = int'($urandom % 7);
      v = $urandom;
      case (op)
        0: begin busWrite(8'h00, v); mFunc = v[15:0]; end
        1: begin busWrite(8'h20, v); mDir = v[31:24]; mOut = v[23:16]; end
        2: begin busWrite(8'h24, v); mOut = mOut | v[7:0]; end
        3: begin busWrite(8'h28, v); mOut = mOut & ~v[7:0]; end
        4: begin busWrite(8'h2C, v); mPull = v[7:0]; end
        5: begin
          @(negedge clk); padIn = v[7:0];
          repeat (2) @(negedge clk);
          mPin = v[7:0];
          busRead(8'h20, rd); chk("R4/R5 random read", rd, expData());
        end
        default: begin busWrite(8'h30 + 8'(v[3:0]), v); end
      endcase
      checkOutputs("R2/R3/R6/R7/R8 random");
    end
    busRead(8'h20, rd); chk("R4/R5 final read", rd, expData());

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule